// File: doc/BRIEF.md
# Parallel Port Printer Control Register

This block is the host-side control register of a PC-style printer port. The host writes one byte. The block stores the six usable bits and turns them into the three active-low printer control pins. It also produces the port's effective transfer direction. The same stored byte can be read back at any time on a separate read bus.

Each control pin has its own polarity. The line-feed and printer-select bits are inverted on their way to the pins. The initialize bit drives its pin unchanged. The direction bit can ask for input. However, the effective direction stays at output while the port runs in the plain compatibility mode or the compatibility FIFO mode.

The acknowledge input comes from the printer and is asynchronous. The block first synchronizes it and then watches it for a low-to-high transition. When the interrupt enable bit is set, each such transition raises a single-cycle interrupt request toward the host.

Top module: `pport_ctrl_reg`

## Requirements
- R1: While rst_ni is low, and after it is released with no write, rd_data_o is 8'h00, autofd_n_o is 1, slctin_n_o is 1, init_n_o is 0, dir_in_o is 0 and irq_o is 0.
- R2: A clock edge with wr_en_i high stores wr_data_i[5:0]. From the following cycle, rd_data_o[5:0] shows the stored bits unchanged, including bit 0, which drives no pin.
- R3: rd_data_o[7:6] is always 2'b00, whatever was written to wr_data_i[7:6].
- R4: autofd_n_o is the inverse of stored bit 1 (1 means a line feed is requested after each line).
- R5: init_n_o equals stored bit 2, with no inversion.
- R6: slctin_n_o is the inverse of stored bit 3 (1 means the printer is selected).
- R7: When mode_i is not 3'b000 and not 3'b010, dir_in_o equals stored bit 5 (0 means output, 1 means input).
- R8: When mode_i is 3'b000 or 3'b010, dir_in_o is 0 whatever stored bit 5 holds.
- R9: With stored bit 4 set, a rise of ack_n_i makes irq_o high for exactly one cycle. The rise is first seen as 1 at clock edge k after being 0 at edge k-1, and irq_o is high in the cycle that follows edge k+2.
- R10: With stored bit 4 clear, a rise of ack_n_i leaves irq_o at 0.
- R11: A fall of ack_n_i, or ack_n_i held at either level, never raises irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data byte |
| rd_data_o | output | 8 | Register read-back byte |
| mode_i | input | 3 | Current port mode |
| ack_n_i | input | 1 | Printer acknowledge, asynchronous |
| autofd_n_o | output | 1 | Auto line feed pin, active low |
| init_n_o | output | 1 | Initialize pin |
| slctin_n_o | output | 1 | Printer select pin, active low |
| dir_in_o | output | 1 | Effective direction, 1 = input |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The hardest case to reach from the ports is the exact placement of the interrupt pulse. The acknowledge rise goes through two synchronizer stages and an output register before it shows on irq_o. The bench therefore moves ack_n_i only on falling clock edges and samples irq_o on each of the next four falling edges, so the single high cycle must fall on the third one. It also drops the acknowledge line and holds it at both levels while the enable is set, and sends a clean rise with the enable clear, to show that only a rising edge raises irq_o.

// File: rtl/pport_ctrl_pkg.sv
package pport_ctrl_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned MODE_W = 3;

  localparam int unsigned BIT_AUTOFD = 1;
  localparam int unsigned BIT_INIT   = 2;
  localparam int unsigned BIT_SELECT = 3;
  localparam int unsigned BIT_IRQ_EN = 4;
  localparam int unsigned BIT_DIR    = 5;

  localparam logic [REG_W-1:0] WR_MASK = 8'h3f;

  localparam logic [MODE_W-1:0] MODE_COMPAT      = 3'b000;
  localparam logic [MODE_W-1:0] MODE_COMPAT_FIFO = 3'b010;

  typedef logic [REG_W-1:0]  ctrl_reg_t;
  typedef logic [MODE_W-1:0] port_mode_t;
endpackage

// File: rtl/pport_ctrl_store.sv
module pport_ctrl_store #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_rw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      q[i] <= 1'b0;
        else if (wr_en_i) q[i] <= wr_data_i[i];
      end
    end else begin : g_ro
      assign q[i] = 1'b0;
    end
  end

  assign q_o = q;
endmodule

// File: rtl/pport_ack_edge.sv
module pport_ack_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_n_i,
  input  logic en_i,
  output logic irq_o
);
  localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] sync_q;
  logic         prev_q;
  logic         irq_q;
  logic         rise;

  // idle level of the line is high; reset to it so release makes no edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[N-2:0], ack_n_i};
      prev_q <= sync_q[N-1];
      irq_q  <= rise & en_i;
    end
  end

  assign rise  = sync_q[N-1] & ~prev_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/pport_pin_map.sv
module pport_pin_map
  import pport_ctrl_pkg::*;
(
  input  ctrl_reg_t  ctrl_i,
  input  port_mode_t mode_i,
  output logic       autofd_n_o,
  output logic       init_n_o,
  output logic       slctin_n_o,
  output logic       dir_in_o
);
  logic dir_forced_out;

  always_comb begin
    dir_forced_out = (mode_i == MODE_COMPAT) || (mode_i == MODE_COMPAT_FIFO);
    autofd_n_o     = ~ctrl_i[BIT_AUTOFD];
    init_n_o       =  ctrl_i[BIT_INIT];
    slctin_n_o     = ~ctrl_i[BIT_SELECT];
    dir_in_o       = ctrl_i[BIT_DIR] & ~dir_forced_out;
  end
endmodule

// File: rtl/pport_ctrl_reg.sv
module pport_ctrl_reg
  import pport_ctrl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              ack_n_i,
  output logic              autofd_n_o,
  output logic              init_n_o,
  output logic              slctin_n_o,
  output logic              dir_in_o,
  output logic              irq_o
);
  ctrl_reg_t ctrl_q;

  pport_ctrl_store #(
    .W    (REG_W),
    .MASK (WR_MASK)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .q_o       (ctrl_q)
  );

  pport_pin_map u_pins (
    .ctrl_i     (ctrl_q),
    .mode_i     (mode_i),
    .autofd_n_o (autofd_n_o),
    .init_n_o   (init_n_o),
    .slctin_n_o (slctin_n_o),
    .dir_in_o   (dir_in_o)
  );

  pport_ack_edge #(
    .STAGES (SYNC_STAGES)
  ) u_ack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ack_n_i (ack_n_i),
    .en_i    (ctrl_q[BIT_IRQ_EN]),
    .irq_o   (irq_o)
  );

  assign rd_data_o = ctrl_q;
endmodule

// File: rtl/pport_ctrl_reg_chk.sv
module pport_ctrl_reg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] rd_data_o,
  input logic [2:0] mode_i,
  input logic       ack_n_i,
  input logic       autofd_n_o,
  input logic       init_n_o,
  input logic       slctin_n_o,
  input logic       dir_in_o,
  input logic       irq_o
);
  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[5:0] == $past(wr_data_i[5:0]));

  a_r3_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[7:6] == 2'b00);

  a_r4_autofd_inv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    autofd_n_o == ~rd_data_o[1]);

  a_r5_init_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_n_o == rd_data_o[2]);

  a_r6_select_inv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slctin_n_o == ~rd_data_o[3]);

  a_r7_dir_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 3'b000 && mode_i != 3'b010) |-> dir_in_o == rd_data_o[5]);

  a_r8_dir_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'b000 || mode_i == 3'b010) |-> !dir_in_o);

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  a_r10_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(rd_data_o[4]));

  a_r11_rise_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(ack_n_i, 3) && !$past(ack_n_i, 4)));
endmodule

bind pport_ctrl_reg pport_ctrl_reg_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .rd_data_o  (rd_data_o),
  .mode_i     (mode_i),
  .ack_n_i    (ack_n_i),
  .autofd_n_o (autofd_n_o),
  .init_n_o   (init_n_o),
  .slctin_n_o (slctin_n_o),
  .dir_in_o   (dir_in_o),
  .irq_o      (irq_o)
);

// File: tb/pport_ctrl_reg_tb_top.sv
module pport_ctrl_reg_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] rd_data_o;
  logic [2:0] mode_i = 3'b001;
  logic       ack_n_i = 1'b1;
  logic       autofd_n_o, init_n_o, slctin_n_o, dir_in_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  pport_ctrl_reg dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .rd_data_o  (rd_data_o),
    .mode_i     (mode_i),
    .ack_n_i    (ack_n_i),
    .autofd_n_o (autofd_n_o),
    .init_n_o   (init_n_o),
    .slctin_n_o (slctin_n_o),
    .dir_in_o   (dir_in_o),
    .irq_o      (irq_o)
  );

  // {mode, write byte, expected read, expected {autofd_n, init_n, slctin_n, dir_in}}
  localparam int NV = 10;
  localparam logic [22:0] VEC [NV] = '{
    {3'b001, 8'hff, 8'h3f, 4'b0101},
    {3'b000, 8'hff, 8'h3f, 4'b0100},
    {3'b010, 8'h20, 8'h20, 4'b1010},
    {3'b011, 8'h20, 8'h20, 4'b1011},
    {3'b110, 8'h02, 8'h02, 4'b0010},
    {3'b111, 8'h04, 8'h04, 4'b1110},
    {3'b100, 8'h08, 8'h08, 4'b1000},
    {3'b101, 8'hc1, 8'h01, 4'b1010},
    {3'b001, 8'h2a, 8'h2a, 4'b0001},
    {3'b010, 8'h3f, 8'h3f, 4'b0100}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] d);
    wr_en_i = 1'b1;
    wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  function automatic logic [12:0] outs();
    return {rd_data_o, autofd_n_o, init_n_o, slctin_n_o, dir_in_o, irq_o};
  endfunction

  task automatic count_irq(input int cycles, output int cnt);
    cnt = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk_i);
      if (irq_o) cnt++;
    end
  endtask

  initial begin
    int cnt;
    // R1 reset state during and after reset
    @(negedge clk_i);
    check("R1 in reset", 32'(outs()), 32'({8'h00, 4'b1010, 1'b0}));
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1 after release", 32'(outs()), 32'({8'h00, 4'b1010, 1'b0}));

    // R2 R3 R4 R5 R6 R7 R8 vector walk; ack held high so R11 level-hold too
    for (int v = 0; v < NV; v++) begin
      mode_i = VEC[v][22:20];
      write_reg(VEC[v][19:12]);
      check("R2 R3 R4 R5 R6 R7 R8 vector", 32'(outs()), 32'({VEC[v][11:0], 1'b0}));
    end

    // R8 mode change alone with bit 5 set
    write_reg(8'h20);
    mode_i = 3'b000;
    #1 check("R8 forced out", 32'(dir_in_o), 32'd0);
    mode_i = 3'b111;
    #1 check("R7 dir input", 32'(dir_in_o), 32'd1);

    // R9 exact pulse placement
    write_reg(8'h10);
    ack_n_i = 1'b0;
    repeat (4) @(negedge clk_i);
    check("R11 fall no irq", 32'(irq_o), 32'd0);
    ack_n_i = 1'b1;
    @(negedge clk_i); check("R9 edge+1 low", 32'(irq_o), 32'd0);
    @(negedge clk_i); check("R9 edge+2 low", 32'(irq_o), 32'd0);
    @(negedge clk_i); check("R9 edge+3 high", 32'(irq_o), 32'd1);
    @(negedge clk_i); check("R9 edge+4 low", 32'(irq_o), 32'd0);
    count_irq(6, cnt);
    check("R9 R11 no repeat while high", 32'(cnt), 32'd0);

    // R11 falling edge and low hold with enable set
    ack_n_i = 1'b0;
    count_irq(8, cnt);
    check("R11 fall and low hold", 32'(cnt), 32'd0);

    // R10 enable clear
    write_reg(8'h00);
    ack_n_i = 1'b1;
    count_irq(8, cnt);
    check("R10 disabled", 32'(cnt), 32'd0);

    // R9 short one-cycle acknowledge low pulse still seen
    write_reg(8'h10);
    ack_n_i = 1'b0;
    @(negedge clk_i);
    ack_n_i = 1'b1;
    count_irq(8, cnt);
    check("R9 short pulse count", 32'(cnt), 32'd1);

    // R1 reset mid-run clears state
    mode_i = 3'b001;
    write_reg(8'h3f);
    rst_ni = 1'b0;
    #1 check("R1 async clear", 32'(outs()), 32'({8'h00, 4'b1010, 1'b0}));
    @(negedge clk_i);
    rst_ni = 1'b1;
    count_irq(6, cnt);
    check("R1 no irq after release", 32'(cnt), 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule